// File: doc/BRIEF.md
# Credit-Based DMA Channel Flow Controller

This block is the flow-control core of a multi-channel DMA engine that serves peripherals which hold their own FIFOs. The peripheral sends no fill level. For every word that moves through its FIFO it sends a one-cycle strobe on that channel's pin, and nothing else. Each channel keeps its own counter from those strobes and from the bursts the DMA starts. For memory-to-peripheral (transmit) channels, the counter holds free slots in the remote FIFO. For peripheral-to-memory (receive) channels, it holds words waiting there.

Each channel has two programmed values. The first is a FIFO size, given in blocks of 16 words. It must match the peripheral's real depth: a larger value leads to overrun, and a smaller one holds back bursts that would fit, leading to underrun. The second is a burst length of 1 to 16 words, set independently of the FIFO size. The channel offers a burst on a valid/ready pair when the counter covers a full burst. It reserves the burst when the request is accepted, and it waits for a burst-done pulse before it offers the next one.

Back-pressure rules: `req_valid` rises only when a full burst fits. Once raised, it stays high until `req_ready` accepts it or the channel is disabled. The DMA datapath may hold `req_ready` low as long as it likes. Asserting `req_ready` while `req_valid` is low is a protocol error.

Top module: `dma_credit_flow`

## Requirements
- R1: After reset, every channel has `req_valid` and `proto_err` low, a FIFO size of 1 block (16 words), a burst length of 1 and direction transmit (`cfg_dir` = 0). Receive is `cfg_dir` = 1.
- R2: On the first clock edge where a channel's enable is high after being low, the counter loads the FIFO size (transmit) or 0 (receive), the outstanding burst is cleared and `proto_err` is cleared. Strobes, grants and done pulses in that cycle have no other effect.
- R3: On an enabled transmit channel, each strobe adds one credit, each accepted request removes burst-length credits, and `req_valid` is high only while credits are at least the burst length and no burst is outstanding.
- R4: On an enabled receive channel, each strobe adds one available word, each accepted request removes burst-length words, and `req_valid` follows the same rule as for transmit.
- R5: After a request is accepted (`req_valid` and `req_ready` both high at an edge), `req_valid` stays low until a `burst_done` pulse. While `req_valid` is high and not accepted, it stays high unless the channel is disabled. A `burst_done` with no burst outstanding has no effect.
- R6: A strobe that arrives on an enabled channel whose counter equals the FIFO size, with no grant in the same cycle, sets `proto_err` and leaves the counter unchanged.
- R7: `req_ready` high while `req_valid` is low sets `proto_err` and leaves the counter unchanged.
- R8: `proto_err` stays set until the next enable of its channel (R2).
- R9: A configuration write to a channel whose enable is high at that edge is ignored.
- R10: A configuration write whose block count is 0 or above 64, or whose burst length is 0 or above 16, is ignored as a whole.
- R11: The FIFO size in words is the block count times 16. The burst length is set independently of it.
- R12: A strobe and a grant in the same cycle are both applied. Every result appears after the clock edge that samples its inputs, except the drop of `req_valid` when the enable falls, which is immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_enable | input | NUM_CH | Per-channel enable, level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Channel addressed by the write |
| cfg_blocks | input | BLK_W | FIFO size in 16-word blocks (1..64) |
| cfg_burst | input | BURST_W | Burst length in words (1..16) |
| cfg_dir | input | 1 | 0 transmit, 1 receive |
| per_strobe | input | NUM_CH | One pulse per word moved by the peripheral |
| req_valid | output | NUM_CH | Burst request offered |
| req_ready | input | NUM_CH | Burst request accepted |
| burst_done | input | NUM_CH | Accepted burst has completed |
| proto_err | output | NUM_CH | Sticky protocol error |

## Verification
Every counter, outstanding-burst and error update is registered once, so a strobe, grant, done pulse, enable or configuration write sampled at one rising edge shows in `req_valid` and `proto_err` after that edge. The exception is a falling enable, which drops `req_valid` at once. The bench applies inputs after the falling edge and advances its model by exactly one edge per step. It compares both outputs on the next falling edge, before the inputs change. The comparison therefore sees the same enable level the design sees.

// File: rtl/dma_flow_pkg.sv
`timescale 1ns/1ps
package dma_flow_pkg;
  typedef enum logic {
    XFER_TX = 1'b0,
    XFER_RX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/dma_flow_cfg.sv
`timescale 1ns/1ps
module dma_flow_cfg
  import dma_flow_pkg::*;
#(
  parameter int FIFO_GRAIN = 16,
  parameter int MAX_FIFO   = 1024,
  parameter int MAX_BURST  = 16,
  localparam int MAX_BLK   = MAX_FIFO / FIFO_GRAIN,
  localparam int BLK_W     = $clog2(MAX_BLK + 1),
  localparam int CNT_W     = $clog2(MAX_FIFO + 1),
  localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               we,
  input  logic [BLK_W-1:0]   blocks,
  input  logic [BURST_W-1:0] burst,
  input  logic               dir_in,
  output logic [CNT_W-1:0]   size_o,
  output logic [BURST_W-1:0] burst_o,
  output xfer_dir_e          dir_o
);
  logic [BLK_W-1:0] blk_q;
  logic             legal;

  assign legal = (blocks != '0) && (blocks <= BLK_W'(MAX_BLK)) &&
                 (burst != '0) && (burst <= BURST_W'(MAX_BURST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= BLK_W'(1);
      burst_o <= BURST_W'(1);
      dir_o   <= XFER_TX;
    end else if (we && !en && legal) begin
      blk_q   <= blocks;
      burst_o <= burst;
      dir_o   <= xfer_dir_e'(dir_in);
    end
  end

  assign size_o = CNT_W'(blk_q) * CNT_W'(FIFO_GRAIN);

  // locked while enabled
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && en) |=> ($stable(size_o) && $stable(burst_o) && $stable(dir_o)));

  p_size_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (size_o != '0) && (size_o <= CNT_W'(MAX_FIFO)));
endmodule

// File: rtl/dma_flow_credit.sv
`timescale 1ns/1ps
module dma_flow_credit
  import dma_flow_pkg::*;
#(
  parameter int MAX_FIFO  = 1024,
  parameter int MAX_BURST = 16,
  localparam int CNT_W    = $clog2(MAX_FIFO + 1),
  localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [CNT_W-1:0]   size,
  input  logic [BURST_W-1:0] burst,
  input  xfer_dir_e          dir,
  input  logic               strobe,
  input  logic               ready,
  input  logic               done,
  output logic               valid,
  output logic               err
);
  logic             en_q, busy;
  logic [CNT_W-1:0] cnt, cnt_nxt, take_amt;
  logic             active, rise, take, bad_grant, at_top, ovf, inc;

  assign active    = en & en_q;
  assign rise      = en & ~en_q;
  assign valid     = active & ~busy & (cnt >= CNT_W'(burst));
  assign take      = ready & valid;
  assign bad_grant = ready & ~valid;
  assign at_top    = (cnt == size);
  assign ovf       = active & strobe & at_top & ~take;
  assign inc       = active & strobe & ~ovf;
  assign take_amt  = take ? CNT_W'(burst) : '0;
  assign cnt_nxt   = cnt + CNT_W'(inc) - take_amt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
      err  <= 1'b0;
    end else begin
      en_q <= en;
      if (rise) begin
        cnt  <= (dir == XFER_RX) ? '0 : size;
        busy <= 1'b0;
        err  <= 1'b0;
      end else begin
        cnt <= cnt_nxt;
        if (take)      busy <= 1'b1;
        else if (done) busy <= 1'b0;
        if (bad_grant || ovf) err <= 1'b1;
      end
    end
  end

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt == ((dir == XFER_RX) ? '0 : size)) && !err);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= size));

  p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe && at_top && !ready) |=> (err && $stable(cnt)));

  p_grant_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !valid);

  p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid || !en));

  p_bad_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !valid && !rise) |=> err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !rise) |=> err);
endmodule

// File: rtl/dma_credit_flow.sv
`timescale 1ns/1ps
module dma_credit_flow
  import dma_flow_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int FIFO_GRAIN = 16,
  parameter int MAX_FIFO   = 1024,
  parameter int MAX_BURST  = 16,
  localparam int MAX_BLK   = MAX_FIFO / FIFO_GRAIN,
  localparam int BLK_W     = $clog2(MAX_BLK + 1),
  localparam int CNT_W     = $clog2(MAX_FIFO + 1),
  localparam int BURST_W   = $clog2(MAX_BURST + 1),
  localparam int SEL_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  ch_enable,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [BLK_W-1:0]   cfg_blocks,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic               cfg_dir,
  input  logic [NUM_CH-1:0]  per_strobe,
  output logic [NUM_CH-1:0]  req_valid,
  input  logic [NUM_CH-1:0]  req_ready,
  input  logic [NUM_CH-1:0]  burst_done,
  output logic [NUM_CH-1:0]  proto_err
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CNT_W-1:0]   size_w;
    logic [BURST_W-1:0] burst_w;
    xfer_dir_e          dir_w;
    logic               we_w;

    assign we_w = cfg_we && (cfg_sel == SEL_W'(g));

    dma_flow_cfg #(
      .FIFO_GRAIN(FIFO_GRAIN), .MAX_FIFO(MAX_FIFO), .MAX_BURST(MAX_BURST)
    ) u_cfg (
      .clk(clk), .rst_n(rst_n), .en(ch_enable[g]), .we(we_w),
      .blocks(cfg_blocks), .burst(cfg_burst), .dir_in(cfg_dir),
      .size_o(size_w), .burst_o(burst_w), .dir_o(dir_w)
    );

    dma_flow_credit #(
      .MAX_FIFO(MAX_FIFO), .MAX_BURST(MAX_BURST)
    ) u_credit (
      .clk(clk), .rst_n(rst_n), .en(ch_enable[g]),
      .size(size_w), .burst(burst_w), .dir(dir_w),
      .strobe(per_strobe[g]), .ready(req_ready[g]), .done(burst_done[g]),
      .valid(req_valid[g]), .err(proto_err[g])
    );
  end
endmodule

// File: tb/dma_credit_flow_test.sv
`timescale 1ns/1ps
module dma_credit_flow_test;
  localparam int NCH = 2;
  localparam int BLK_W = 7;
  localparam int BURST_W = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic [NCH-1:0]     en, stb, rdy, done, vld, perr;
  logic               cfg_we, cfg_dir;
  logic [0:0]         cfg_sel;
  logic [BLK_W-1:0]   cfg_blocks;
  logic [BURST_W-1:0] cfg_burst;

  dma_credit_flow uut (
    .clk(clk), .rst_n(rst_n), .ch_enable(en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_blocks(cfg_blocks), .cfg_burst(cfg_burst), .cfg_dir(cfg_dir),
    .per_strobe(stb), .req_valid(vld), .req_ready(rdy), .burst_done(done),
    .proto_err(perr)
  );

  int checks = 0, fails = 0;
  int m_cnt[NCH], m_size[NCH], m_burst[NCH], m_dir[NCH];
  bit m_q[NCH], m_busy[NCH], m_err[NCH];

  function automatic bit exp_valid(int c);
    return m_q[c] && en[c] && !m_busy[c] && (m_cnt[c] >= m_burst[c]);
  endfunction

  function automatic bit cfg_legal(int b, int bu);
    return (b >= 1) && (b <= 64) && (bu >= 1) && (bu <= 16);
  endfunction

  task automatic model_next();
    for (int c = 0; c < NCH; c++) begin
      bit v, take;
      int inc;
      v = exp_valid(c);
      if (en[c] && !m_q[c]) begin
        m_cnt[c] = m_dir[c] ? 0 : m_size[c];
        m_busy[c] = 0; m_err[c] = 0;
      end else begin
        take = rdy[c] && v;
        if (rdy[c] && !v) m_err[c] = 1;
        inc = 0;
        if (en[c] && m_q[c] && stb[c]) begin
          if (m_cnt[c] == m_size[c] && !take) m_err[c] = 1;
          else inc = 1;
        end
        m_cnt[c] = m_cnt[c] + inc - (take ? m_burst[c] : 0);
        if (take) m_busy[c] = 1;
        else if (done[c]) m_busy[c] = 0;
      end
      m_q[c] = en[c];
    end
    if (cfg_we && !en[cfg_sel] && cfg_legal(int'(cfg_blocks), int'(cfg_burst))) begin
      m_size[cfg_sel]  = int'(cfg_blocks) * 16;
      m_burst[cfg_sel] = int'(cfg_burst);
      m_dir[cfg_sel]   = int'(cfg_dir);
    end
  endtask

  task automatic check(string tag);
    for (int c = 0; c < NCH; c++) begin
      bit ev;
      ev = exp_valid(c);
      checks++;
      if (vld[c] !== ev) begin
        fails++;
        $display("FAIL %s ch%0d req_valid actual=%0b expected=%0b", tag, c, vld[c], ev);
      end
      checks++;
      if (perr[c] !== m_err[c]) begin
        fails++;
        $display("FAIL %s ch%0d proto_err actual=%0b expected=%0b", tag, c, perr[c], m_err[c]);
      end
    end
  endtask

  task automatic step(string tag);
    model_next();
    @(posedge clk);
    @(negedge clk);
    check(tag);
    stb = '0; rdy = '0; done = '0; cfg_we = 1'b0;
  endtask

  task automatic cfg(int sel, int b, int bu, int d, string tag);
    cfg_we = 1'b1; cfg_sel = 1'(sel); cfg_blocks = BLK_W'(b);
    cfg_burst = BURST_W'(bu); cfg_dir = 1'(d);
    step(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = '0; stb = '0; rdy = '0; done = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_blocks = '0; cfg_burst = '0; cfg_dir = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0; m_size[c] = 16; m_burst[c] = 1; m_dir[c] = 0;
      m_q[c] = 0; m_busy[c] = 0; m_err[c] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    // R1: default config, 16-word TX burst 1
    en[0] = 1'b1; step("R1");
    step("R1");
    rdy[0] = 1'b1; step("R3");
    done[0] = 1'b1; step("R5");
    en[0] = 1'b0; step("R2");
    // R10: illegal writes ignored
    cfg(0, 0, 4, 1, "R10");
    cfg(0, 65, 4, 1, "R10");
    cfg(0, 2, 0, 1, "R10");
    cfg(0, 2, 17, 1, "R10");
    // R11: sizes and independent bursts
    cfg(0, 1, 16, 0, "R11");
    cfg(1, 2, 4, 1, "R11");
    en = 2'b11; step("R2");
    step("R2");
    // R3: drain then refill transmit credits
    rdy[0] = 1'b1; step("R3");
    done[0] = 1'b1; step("R3");
    for (int i = 0; i < 16; i++) begin stb[0] = 1'b1; step("R3"); end
    // R6/R8: overflow strobe
    stb[0] = 1'b1; step("R6");
    repeat (3) step("R8");
    // R9: write while enabled
    cfg(0, 4, 2, 1, "R9");
    en[0] = 1'b0; step("R8");
    en[0] = 1'b1; step("R2");
    step("R2");
    // R4/R5: receive side
    for (int i = 0; i < 4; i++) begin stb[1] = 1'b1; step("R4"); end
    repeat (4) step("R5");
    done[1] = 1'b1; step("R5");
    rdy[1] = 1'b1; step("R4");
    stb[1] = 1'b1; step("R5");
    // R7: grant without request
    rdy[1] = 1'b1; step("R7");
    // R12: strobe with grant
    rdy[0] = 1'b1; stb[0] = 1'b1; step("R12");
    done[0] = 1'b1; step("R12");
    // constrained random
    for (int n = 0; n < 5000; n++) begin
      for (int c = 0; c < NCH; c++) begin
        int r;
        r = int'($urandom % 100);
        if (m_cnt[c] == m_size[c]) stb[c] = (r < 4);
        else stb[c] = (r < 45);
        r = int'($urandom % 100);
        rdy[c] = exp_valid(c) ? (r < 50) : (r < 2);
        r = int'($urandom % 100);
        done[c] = m_busy[c] ? (r < 30) : (r < 5);
        if (($urandom % 100) < 1) en[c] = ~en[c];
      end
      if (($urandom % 100) < 3) begin
        cfg_we = 1'b1; cfg_sel = 1'($urandom % 2);
        cfg_blocks = BLK_W'($urandom % 70); cfg_burst = BURST_W'($urandom % 19);
        cfg_dir = 1'($urandom % 2);
      end
      step("R12");
    end
    finish_run();
  end
endmodule